// File: doc/BRIEF.md
# Data Cache Maintenance Engine

This block carries out maintenance commands on the valid, dirty and tag state of a four-way, set-associative, write-back data cache. Software reaches it through a small auxiliary register port that has an address, write data, a write strobe, combinational read data and a ready signal that stalls writes. A write to a command address starts one of four operations: invalidate the whole cache, write back the whole cache, invalidate one line, or write back one line. Dirty lines leave through a request/acknowledge handshake to the memory side. That handshake carries the tag, set and way of the line.

A control register holds three bits: one that disables the cache, one for invalidate mode, and a read-only busy flag. Invalidate mode chooses whether an invalidate drops dirty lines or writes them back first. A line operation takes two writes. The first gives the physical address whose tag is matched. The second gives the virtual address, and the set index is taken from it. Whole-cache operations visit one entry per clock. The cache's lookup and refill side updates entries through a state-write port.

The geometry comes from two 4-bit configuration parameters. The line length is 16 bytes shifted left by `LINE_CFG`. The cache size is 512 bytes shifted left by `SIZE_CFG`. The defaults give 32-byte lines, 32 sets and 22-bit tags.

Top module: `dcache_maint`

## Requirements
- R1: After reset, every entry is invalid and clean, the control register reads 0 (cache enabled, discard mode, not busy), wbReq is low and auxReady is high.
- R2: The control register is at address 0x048. Bit 0 is the cache-disable bit and also drives cacheOff. Bit 6 is the invalidate mode. Bit 8 is busy and is read-only: writes to bit 8 have no effect.
- R3: The tag register at address 0x05C stores a full 32-bit physical address and reads back unchanged. Its bits above the offset and index fields, [31:10] by default, form the tag that a line operation matches.
- R4: Writing 1 in bit 0 to address 0x047 invalidates the whole cache. Writing 1 in bit 0 to address 0x04B writes back the whole cache. A write with bit 0 clear does nothing. A whole-cache walk visits sets in ascending order and, within each set, ways 0 to 3 in order, one entry per cycle.
- R5: A flush writes back every valid dirty entry it reaches, then clears the dirty bit and leaves the entry valid. Clean or invalid entries produce no writeback.
- R6: With mode 0, an invalidate clears valid and dirty with no writeback. With mode 1, an invalidate first writes back a valid dirty entry and then clears it. The mode value in force when the command is accepted is the one used.
- R7: wbReq stays high, with wbTag, wbSet and wbWay unchanged, until wbAck is seen. Each acknowledged request is exactly one writeback.
- R8: A write to address 0x04A invalidates one line, and a write to 0x04C writes back one line. The set is taken from write-data bits [9:5] by default. The lowest-numbered way in that set that is valid and whose tag equals the tag register's tag field is the one acted on. A line operation ends once its single writeback is acknowledged.
- R9: A line operation that finds no matching way does no writeback and changes no state.
- R10: Busy reads as 1 from the cycle after a command is accepted until the operation ends. While busy, writes to 0x047, 0x048, 0x04A, 0x04B, 0x04C and 0x05C are held off with auxReady low and take effect once the operation ends. Reads are never stalled.
- R11: A pulse on fillEn makes the entry at fillSet/fillWay valid, with tag fillTag and the dirty value fillDirty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| auxAddr | input | 12 | Register address |
| auxWrEn | input | 1 | Write strobe |
| auxWrData | input | 32 | Write data |
| auxRdData | output | 32 | Read data for auxAddr, combinational |
| auxReady | output | 1 | Low while a maintenance write is stalled |
| cacheOff | output | 1 | Cache-disable bit |
| fillEn | input | 1 | State-write strobe from the lookup/refill side |
| fillSet | input | IDX_W (5) | Set to write |
| fillWay | input | 2 | Way to write |
| fillTag | input | TAG_W (22) | Tag to store |
| fillDirty | input | 1 | Dirty value to store |
| wbReq | output | 1 | Writeback request |
| wbAck | input | 1 | Writeback acknowledge |
| wbTag | output | TAG_W (22) | Tag of the line being written back |
| wbSet | output | IDX_W (5) | Set of the line being written back |
| wbWay | output | 2 | Way of the line being written back |

## Verification
The assertions check, on every cycle, the behaviour that can be stated from one clock to the next. A pending writeback request stays up until it is acknowledged. The latched operation and the tag register do not change while busy. Every committed entry is clean on the following cycle, and an invalidate leaves it invalid. The walk pointer never steps past the last entry. A line operation ends right after its acknowledge. The bench scenarios cover what depends on history. They compare the full order of writebacks against a reference model across random fill patterns, both invalidate modes and all four operations. They also check that lines missed or skipped stay dirty, that stalled writes are applied late rather than dropped, and that commands with bit 0 clear do nothing.

// File: rtl/dcm_pkg.sv
package dcm_pkg;

  localparam int AUX_AW = 12;
  localparam int AUX_DW = 32;

  // Command and register addresses (decoded by software-visible contract)
  localparam logic [AUX_AW-1:0] ADR_INV_ALL    = 12'h047;
  localparam logic [AUX_AW-1:0] ADR_CTRL       = 12'h048;
  localparam logic [AUX_AW-1:0] ADR_INV_LINE   = 12'h04A;
  localparam logic [AUX_AW-1:0] ADR_FLUSH_ALL  = 12'h04B;
  localparam logic [AUX_AW-1:0] ADR_FLUSH_LINE = 12'h04C;
  localparam logic [AUX_AW-1:0] ADR_TAG        = 12'h05C;

  // Control register bit positions
  localparam int BIT_OFF   = 0;
  localparam int BIT_INVWB = 6;
  localparam int BIT_BUSY  = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WALK,
    ST_LINE,
    ST_WB
  } engState_t;

  // Strobes from the sequencer to the state array
  typedef struct packed {
    logic lineMode;    // target comes from the line search, not the walk pointer
    logic ptrReset;    // return walk pointer to entry 0
    logic ptrStep;     // advance walk pointer
    logic commit;      // apply the update to the target entry
    logic clearValid;  // commit also drops the valid bit
  } engStrobe_t;

  function automatic logic isMaintAddr(input logic [AUX_AW-1:0] a);
    return (a == ADR_INV_ALL) || (a == ADR_CTRL) || (a == ADR_INV_LINE) ||
           (a == ADR_FLUSH_ALL) || (a == ADR_FLUSH_LINE) || (a == ADR_TAG);
  endfunction

endpackage

// File: rtl/dcm_state.sv
module dcm_state import dcm_pkg::*; #(
  parameter int SETS  = 32,
  parameter int WAYS  = 4,
  parameter int TAG_W = 22,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int PTR_W = IDX_W + WAY_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  engStrobe_t       stb,
  input  logic [IDX_W-1:0] lineSet,
  input  logic [TAG_W-1:0] lineTag,
  input  logic             fillEn,
  input  logic [IDX_W-1:0] fillSet,
  input  logic [WAY_W-1:0] fillWay,
  input  logic [TAG_W-1:0] fillTag,
  input  logic             fillDirty,
  output logic             tgtValid,
  output logic             tgtDirty,
  output logic [TAG_W-1:0] tgtTag,
  output logic [IDX_W-1:0] tgtSet,
  output logic [WAY_W-1:0] tgtWay,
  output logic             lineHit,
  output logic             walkLast
);

  logic [WAYS-1:0]  validQ [SETS];
  logic [WAYS-1:0]  dirtyQ [SETS];
  logic [TAG_W-1:0] tagQ   [SETS][WAYS];

  logic [PTR_W-1:0] walkPtr;
  logic [WAYS-1:0]  hitVec;
  logic [WAY_W-1:0] hitWay;
  logic [IDX_W-1:0] walkSet;
  logic [WAY_W-1:0] walkWay;

  // Walk pointer: way in the low bits so each set is finished before the next
  always_ff @(posedge clk) begin
    if (!rstN)             walkPtr <= '0;
    else if (stb.ptrReset) walkPtr <= '0;
    else if (stb.ptrStep)  walkPtr <= walkPtr + 1'b1;
  end

  assign walkSet  = walkPtr[PTR_W-1:WAY_W];
  assign walkWay  = walkPtr[WAY_W-1:0];
  assign walkLast = (walkPtr == {PTR_W{1'b1}});

  // Per-way tag compare in the addressed set
  generate
    for (genvar w = 0; w < WAYS; w++) begin : gWayCmp
      assign hitVec[w] = validQ[lineSet][w] && (tagQ[lineSet][w] == lineTag);
    end
  endgenerate

  always_comb begin
    hitWay = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hitVec[w]) hitWay = WAY_W'(w);
    end
  end

  assign lineHit  = |hitVec;
  assign tgtSet   = stb.lineMode ? lineSet : walkSet;
  assign tgtWay   = stb.lineMode ? hitWay  : walkWay;
  assign tgtValid = validQ[tgtSet][tgtWay];
  assign tgtDirty = dirtyQ[tgtSet][tgtWay];
  assign tgtTag   = tagQ[tgtSet][tgtWay];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        validQ[s] <= '0;
        dirtyQ[s] <= '0;
      end
    end else begin
      if (stb.commit) begin
        dirtyQ[tgtSet][tgtWay] <= 1'b0;
        if (stb.clearValid) validQ[tgtSet][tgtWay] <= 1'b0;
      end
      if (fillEn) begin
        validQ[fillSet][fillWay] <= 1'b1;
        dirtyQ[fillSet][fillWay] <= fillDirty;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fillEn) tagQ[fillSet][fillWay] <= fillTag;
  end

  // R5: a committed entry is clean on the next cycle
  assert_commit_clean_R5: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit && !fillEn |=> !dirtyQ[$past(tgtSet)][$past(tgtWay)]);

  // R6: an invalidate commit leaves the entry invalid
  assert_inv_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit && stb.clearValid && !fillEn |=> !validQ[$past(tgtSet)][$past(tgtWay)]);

  // R4: the walk never steps beyond the final entry
  assert_walk_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    stb.ptrStep |-> !walkLast);

endmodule

// File: rtl/dcm_ctrl.sv
module dcm_ctrl import dcm_pkg::*; #(
  parameter int OFFS_W = 5,
  parameter int IDX_W  = 5,
  parameter int TAG_W  = 22
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [AUX_AW-1:0] auxAddr,
  input  logic              auxWrEn,
  input  logic [AUX_DW-1:0] auxWrData,
  output logic [AUX_DW-1:0] auxRdData,
  output logic              auxReady,
  output logic              cacheOff,
  output logic              wbReq,
  input  logic              wbAck,
  input  logic              tgtValid,
  input  logic              tgtDirty,
  input  logic              lineHit,
  input  logic              walkLast,
  output engStrobe_t        stb,
  output logic [IDX_W-1:0]  lineSet,
  output logic [TAG_W-1:0]  lineTag
);

  engState_t         state, nextState;
  logic              busy;
  logic              offBit, invModeBit;
  logic [AUX_DW-1:0] tagReg;
  logic              opInv, opWhole, opWb;
  logic              wrFire, startWalk, startLine, cmdIsInv, needWb;

  assign busy     = (state != ST_IDLE);
  assign auxReady = !(auxWrEn && isMaintAddr(auxAddr) && busy);
  assign wrFire   = auxWrEn && auxReady;
  assign cmdIsInv = (auxAddr == ADR_INV_ALL) || (auxAddr == ADR_INV_LINE);

  assign startWalk = wrFire && !busy && auxWrData[0] &&
                     ((auxAddr == ADR_INV_ALL) || (auxAddr == ADR_FLUSH_ALL));
  assign startLine = wrFire && !busy &&
                     ((auxAddr == ADR_INV_LINE) || (auxAddr == ADR_FLUSH_LINE));

  assign lineTag  = tagReg[AUX_DW-1 -: TAG_W];
  assign cacheOff = offBit;
  assign wbReq    = (state == ST_WB);
  assign needWb   = tgtValid && tgtDirty && opWb;

  always_comb begin
    stb            = '0;
    stb.lineMode   = !opWhole;
    stb.ptrReset   = (state == ST_IDLE);
    stb.clearValid = opInv;
    nextState      = state;
    unique case (state)
      ST_IDLE: begin
        if (startWalk)      nextState = ST_WALK;
        else if (startLine) nextState = ST_LINE;
      end
      ST_WALK: begin
        if (needWb) nextState = ST_WB;
        else begin
          stb.commit = 1'b1;
          if (walkLast) nextState = ST_IDLE;
          else          stb.ptrStep = 1'b1;
        end
      end
      ST_LINE: begin
        if (!lineHit)    nextState = ST_IDLE;
        else if (needWb) nextState = ST_WB;
        else begin
          stb.commit = 1'b1;
          nextState  = ST_IDLE;
        end
      end
      ST_WB: begin
        if (wbAck) begin
          stb.commit = 1'b1;
          if (opWhole && !walkLast) begin
            stb.ptrStep = 1'b1;
            nextState   = ST_WALK;
          end else begin
            nextState = ST_IDLE;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      offBit     <= 1'b0;
      invModeBit <= 1'b0;
      tagReg     <= '0;
      opInv      <= 1'b0;
      opWhole    <= 1'b0;
      opWb       <= 1'b0;
      lineSet    <= '0;
    end else begin
      state <= nextState;
      if (wrFire && auxAddr == ADR_CTRL) begin
        offBit     <= auxWrData[BIT_OFF];
        invModeBit <= auxWrData[BIT_INVWB];
      end
      if (wrFire && auxAddr == ADR_TAG) tagReg <= auxWrData;
      if (startWalk || startLine) begin
        opInv   <= cmdIsInv;
        opWhole <= startWalk;
        opWb    <= !cmdIsInv || invModeBit;
      end
      if (startLine) lineSet <= auxWrData[OFFS_W +: IDX_W];
    end
  end

  always_comb begin
    auxRdData = '0;
    if (auxAddr == ADR_CTRL) begin
      auxRdData[BIT_OFF]   = offBit;
      auxRdData[BIT_INVWB] = invModeBit;
      auxRdData[BIT_BUSY]  = busy;
    end else if (auxAddr == ADR_TAG) begin
      auxRdData = tagReg;
    end
  end

  // R7: a pending writeback request is held until acknowledged
  assert_wb_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    wbReq && !wbAck |=> wbReq);

  // R10: the latched operation and tag register stay fixed while busy
  assert_op_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(opInv) && $stable(opWhole) && $stable(opWb) &&
             $stable(lineSet) && $stable(tagReg));

  // R8: a line operation finishes right after its writeback is acknowledged
  assert_line_ends_R8: assert property (@(posedge clk) disable iff (!rstN)
    wbReq && wbAck && !opWhole |=> !busy);

endmodule

// File: rtl/dcache_maint.sv
module dcache_maint import dcm_pkg::*; #(
  parameter int LINE_CFG = 1,
  parameter int SIZE_CFG = 3,
  parameter int WAYS     = 4,
  localparam int LINE_BYTES  = 16 << LINE_CFG,
  localparam int CACHE_BYTES = 512 << SIZE_CFG,
  localparam int SETS        = CACHE_BYTES / (WAYS * LINE_BYTES),
  localparam int OFFS_W      = $clog2(LINE_BYTES),
  localparam int IDX_W       = $clog2(SETS),
  localparam int WAY_W       = $clog2(WAYS),
  localparam int TAG_W       = AUX_DW - OFFS_W - IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [AUX_AW-1:0] auxAddr,
  input  logic              auxWrEn,
  input  logic [AUX_DW-1:0] auxWrData,
  output logic [AUX_DW-1:0] auxRdData,
  output logic              auxReady,
  output logic              cacheOff,
  input  logic              fillEn,
  input  logic [IDX_W-1:0]  fillSet,
  input  logic [WAY_W-1:0]  fillWay,
  input  logic [TAG_W-1:0]  fillTag,
  input  logic              fillDirty,
  output logic              wbReq,
  input  logic              wbAck,
  output logic [TAG_W-1:0]  wbTag,
  output logic [IDX_W-1:0]  wbSet,
  output logic [WAY_W-1:0]  wbWay
);

  engStrobe_t       stb;
  logic [IDX_W-1:0] lineSet;
  logic [TAG_W-1:0] lineTag;
  logic             tgtValid, tgtDirty, lineHit, walkLast;

  dcm_ctrl #(
    .OFFS_W(OFFS_W),
    .IDX_W (IDX_W),
    .TAG_W (TAG_W)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .auxAddr  (auxAddr),
    .auxWrEn  (auxWrEn),
    .auxWrData(auxWrData),
    .auxRdData(auxRdData),
    .auxReady (auxReady),
    .cacheOff (cacheOff),
    .wbReq    (wbReq),
    .wbAck    (wbAck),
    .tgtValid (tgtValid),
    .tgtDirty (tgtDirty),
    .lineHit  (lineHit),
    .walkLast (walkLast),
    .stb      (stb),
    .lineSet  (lineSet),
    .lineTag  (lineTag)
  );

  dcm_state #(
    .SETS (SETS),
    .WAYS (WAYS),
    .TAG_W(TAG_W)
  ) uState (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .lineSet  (lineSet),
    .lineTag  (lineTag),
    .fillEn   (fillEn),
    .fillSet  (fillSet),
    .fillWay  (fillWay),
    .fillTag  (fillTag),
    .fillDirty(fillDirty),
    .tgtValid (tgtValid),
    .tgtDirty (tgtDirty),
    .tgtTag   (wbTag),
    .tgtSet   (wbSet),
    .tgtWay   (wbWay),
    .lineHit  (lineHit),
    .walkLast (walkLast)
  );

endmodule

// File: tb/tb_dcache_maint.sv
`timescale 1ns/1ps
module tb_dcache_maint;

  localparam int SETS = 32;
  localparam int WAYS = 4;
  localparam int TAG_W = 22;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] auxAddr = '0;
  logic        auxWrEn = 1'b0;
  logic [31:0] auxWrData = '0;
  logic [31:0] auxRdData;
  logic        auxReady, cacheOff;
  logic        fillEn = 1'b0;
  logic [4:0]  fillSet = '0;
  logic [1:0]  fillWay = '0;
  logic [21:0] fillTag = '0;
  logic        fillDirty = 1'b0;
  logic        wbReq;
  logic        wbAck = 1'b0;
  logic [21:0] wbTag;
  logic [4:0]  wbSet;
  logic [1:0]  wbWay;

  always #2 clk = ~clk;

  dcache_maint dut (
    .clk(clk), .rstN(rstN), .auxAddr(auxAddr), .auxWrEn(auxWrEn),
    .auxWrData(auxWrData), .auxRdData(auxRdData), .auxReady(auxReady),
    .cacheOff(cacheOff), .fillEn(fillEn), .fillSet(fillSet), .fillWay(fillWay),
    .fillTag(fillTag), .fillDirty(fillDirty), .wbReq(wbReq), .wbAck(wbAck),
    .wbTag(wbTag), .wbSet(wbSet), .wbWay(wbWay)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  bit          mV [SETS][WAYS];
  bit          mD [SETS][WAYS];
  logic [21:0] mT [SETS][WAYS];
  logic [31:0] expWb [256];
  logic [31:0] gotWb [256];
  int expCnt = 0;
  int gotCnt = 0;
  logic [21:0] pool [4] = '{22'h0ABCD, 22'h12345, 22'h3F00F, 22'h00777};

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Writeback target stub: random acknowledge latency, records each writeback
  bit pend = 0;
  logic [31:0] pendVal;
  int delay = 0;
  always @(negedge clk) begin
    if (!rstN) begin
      wbAck = 1'b0;
      pend = 0;
    end else if (wbAck) begin
      wbAck = 1'b0;
    end else if (wbReq) begin
      if (!pend) begin
        pend = 1;
        pendVal = {3'b0, wbTag, wbSet, wbWay};
        delay = $urandom % 4;
      end else begin
        check({3'b0, wbTag, wbSet, wbWay} == pendVal, "R7", "held request fields",
              {3'b0, wbTag, wbSet, wbWay}, pendVal);
      end
      if (delay == 0) begin
        if (gotCnt < 256) gotWb[gotCnt] = pendVal;
        gotCnt++;
        wbAck = 1'b1;
        pend = 0;
      end else begin
        delay--;
      end
    end
  end

  task automatic auxWrite(input logic [11:0] a, input logic [31:0] d, output int stalls);
    @(negedge clk);
    auxAddr = a; auxWrData = d; auxWrEn = 1'b1; stalls = 0;
    #1;
    while (!auxReady) begin
      stalls++;
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    auxWrEn = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    int s;
    auxWrite(a, d, s);
  endtask

  task automatic auxRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    auxAddr = a; auxWrEn = 1'b0;
    #1;
    d = auxRdData;
  endtask

  task automatic waitDone();
    logic [31:0] d;
    int n = 0;
    auxRead(12'h048, d);
    while (d[8] && n < 20000) begin
      auxRead(12'h048, d);
      n++;
    end
    check(!d[8], "R10", "busy clears", d[8], 0);
  endtask

  task automatic fill(input int s, input int w, input logic [21:0] t, input bit dty);
    @(negedge clk);
    fillEn = 1'b1; fillSet = 5'(s); fillWay = 2'(w); fillTag = t; fillDirty = dty;
    @(posedge clk);
    #1;
    fillEn = 1'b0;
    mV[s][w] = 1; mD[s][w] = dty; mT[s][w] = t;
  endtask

  task automatic clearLogs();
    expCnt = 0;
    gotCnt = 0;
  endtask

  task automatic push(input int s, input int w);
    if (expCnt < 256) expWb[expCnt] = {3'b0, mT[s][w], 5'(s), 2'(w)};
    expCnt++;
  endtask

  task automatic modelWalk(input bit inv, input bit wb);
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        if (mV[s][w] && mD[s][w] && wb) push(s, w);
        mD[s][w] = 0;
        if (inv) mV[s][w] = 0;
      end
  endtask

  task automatic modelLine(input bit inv, input bit wb, input int s, input logic [21:0] t);
    for (int w = 0; w < WAYS; w++) begin
      if (mV[s][w] && mT[s][w] == t) begin
        if (mD[s][w] && wb) push(s, w);
        mD[s][w] = 0;
        if (inv) mV[s][w] = 0;
        return;
      end
    end
  endtask

  task automatic compareWb(input string req);
    check(gotCnt == expCnt, req, "writeback count", gotCnt, expCnt);
    for (int i = 0; i < expCnt && i < gotCnt && i < 256; i++)
      check(gotWb[i] == expWb[i], req, "writeback entry", gotWb[i], expWb[i]);
  endtask

  task automatic flushAllCheck(input string req);
    clearLogs();
    modelWalk(0, 1);
    wr(12'h04B, 32'h1);
    waitDone();
    compareWb(req);
  endtask

  task automatic lineOp(input bit inv, input bit mode, input int s, input logic [21:0] t,
                        input string req);
    clearLogs();
    modelLine(inv, inv ? mode : 1'b1, s, t);
    wr(12'h05C, {t, 10'($urandom)});
    wr(inv ? 12'h04A : 12'h04C, {22'($urandom), 5'(s), 5'($urandom)});
    waitDone();
    compareWb(req);
  endtask

  initial begin
    logic [31:0] d;
    int stalls;
    int seedDummy;
    seedDummy = $urandom(32'd20240611);
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        mV[s][w] = 0; mD[s][w] = 0; mT[s][w] = '0;
      end
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: reset state
    auxRead(12'h048, d);
    check(d == 32'h0, "R1", "ctrl after reset", d, 0);
    check(auxReady && !wbReq && !cacheOff, "R1", "ready/req/off after reset",
          {auxReady, wbReq, cacheOff}, 3'b100);
    flushAllCheck("R1");

    // R2: control register fields, busy bit not writable
    wr(12'h048, 32'h0000_0141);
    auxRead(12'h048, d);
    check(d == 32'h41, "R2", "ctrl readback", d, 32'h41);
    check(cacheOff == 1'b1, "R2", "cacheOff", cacheOff, 1);
    wr(12'h048, 32'h0);
    auxRead(12'h048, d);
    check(d == 32'h0 && !cacheOff, "R2", "ctrl cleared", d, 0);

    // R3: tag register readback
    wr(12'h05C, 32'hABCD_E7F3);
    auxRead(12'h05C, d);
    check(d == 32'hABCD_E7F3, "R3", "tag register", d, 32'hABCDE7F3);

    // R11 + R5: fills then flush-all in walk order
    for (int i = 0; i < 24; i++)
      fill($urandom % SETS, $urandom % WAYS, pool[$urandom % 4], $urandom % 2);
    flushAllCheck("R5");
    flushAllCheck("R5");  // now clean: nothing left

    // R4: bit0 clear commands do nothing
    fill(3, 1, pool[0], 1);
    fill(17, 2, pool[1], 1);
    clearLogs();
    wr(12'h04B, 32'hFFFF_FFFE);
    wr(12'h047, 32'h0);
    auxRead(12'h048, d);
    check(!d[8], "R4", "no busy after bit0=0", d[8], 0);
    check(gotCnt == 0, "R4", "no writeback after bit0=0", gotCnt, 0);
    flushAllCheck("R4");

    // R6: discard invalidate-all, then flush sees nothing
    fill(5, 0, pool[2], 1);
    fill(30, 3, pool[3], 1);
    clearLogs();
    modelWalk(1, 0);
    wr(12'h047, 32'h1);
    waitDone();
    compareWb("R6");
    fill(9, 0, pool[0], 0);  // clean line still valid
    flushAllCheck("R6");

    // R6: flush-before invalidate-all
    fill(2, 2, pool[1], 1);
    fill(31, 0, pool[2], 1);
    fill(31, 3, pool[3], 1);
    wr(12'h048, 32'h40);
    clearLogs();
    modelWalk(1, 1);
    wr(12'h047, 32'h1);
    waitDone();
    compareWb("R6");
    flushAllCheck("R6");

    // R8 / R9: directed line operations
    fill(7, 2, pool[0], 1);
    fill(7, 3, pool[1], 1);
    lineOp(0, 0, 7, pool[1], "R8");   // flush-line hit in way 3
    lineOp(0, 0, 7, pool[1], "R8");   // now clean: no writeback
    lineOp(1, 0, 7, pool[3], "R9");   // tag miss
    lineOp(1, 1, 8, pool[0], "R9");   // set miss
    lineOp(1, 1, 7, pool[0], "R8");   // flush-before invalidate hit
    wr(12'h048, 32'h0);
    fill(12, 1, pool[2], 1);
    lineOp(1, 0, 12, pool[2], "R6");  // discard: no writeback
    fill(13, 0, pool[3], 1);
    lineOp(0, 0, 13, pool[0], "R9");  // miss leaves line dirty
    flushAllCheck("R9");

    // R10: busy during walk, stalled writes executed afterwards
    for (int i = 0; i < 16; i++) fill(i * 2, i % 4, pool[i % 4], 1);
    clearLogs();
    modelWalk(0, 1);
    wr(12'h04B, 32'h1);
    auxRead(12'h048, d);
    check(d[8] == 1'b1, "R10", "busy after accept", d[8], 1);
    check(auxReady == 1'b1, "R10", "read not stalled", auxReady, 1);
    auxWrite(12'h05C, {pool[2], 10'h0}, stalls);
    check(stalls > 0, "R10", "tag write stalled", stalls, 1);
    auxRead(12'h05C, d);
    check(d == {pool[2], 10'h0}, "R10", "stalled tag write applied", d, {pool[2], 10'h0});
    waitDone();
    compareWb("R10");
    fill(20, 1, pool[2], 1);
    clearLogs();
    modelWalk(1, 0);
    wr(12'h047, 32'h1);
    modelLine(0, 1, 20, pool[2]);
    auxWrite(12'h04C, {22'h0, 5'd20, 5'h0}, stalls);
    check(stalls > 0, "R10", "line cmd stalled", stalls, 1);
    waitDone();
    compareWb("R10");

    // Random mix of operations and modes
    for (int it = 0; it < 40; it++) begin
      int op;
      bit mode;
      int s;
      logic [21:0] t;
      for (int k = 0; k < 4; k++)
        fill($urandom % SETS, $urandom % WAYS, pool[$urandom % 4], $urandom % 2);
      mode = 1'($urandom % 2);
      wr(12'h048, mode ? 32'h40 : 32'h0);
      op = $urandom % 4;
      s = $urandom % SETS;
      t = ($urandom % 8 == 0) ? 22'($urandom) : pool[$urandom % 4];
      case (op)
        0: begin
          clearLogs(); modelWalk(1, mode);
          wr(12'h047, 32'h1); waitDone(); compareWb("R6");
        end
        1: begin
          clearLogs(); modelWalk(0, 1);
          wr(12'h04B, 32'h1); waitDone(); compareWb("R5");
        end
        2: lineOp(1, mode, s, t, "R8");
        default: lineOp(0, mode, s, t, "R8");
      endcase
    end
    flushAllCheck("R5");

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 190000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule